// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a virtual address into a physical address by walking a single-level page table that lives in ordinary memory. A request carries a 32-bit virtual address and a flag that marks it as a store. The unit splits the address into a page index and a byte offset. It fetches the entry for that page through a request/response memory port, checks the entry, and then either reports the physical address or reports a fault together with its cause.

As a side effect of a successful access, the unit keeps the entry's usage status current in memory. It always marks the page as referenced, and it also marks the page as dirty when the access is a store. These bits go back to memory in one write, and only when the write would change the entry. Software that handles faults fixes the entry and retries. Loading pages and caching translations are left to other logic.

The request side is valid/ready. `req_ready` is high only while the unit is idle, so there is never more than one request in flight. A request is taken on the edge where `req_valid` and `req_ready` are both high, and the requester must hold its fields until then. Results come back as one-cycle pulses (`xl_done` or `xl_fault`) with no back-pressure. The memory request channel is also valid/ready. The unit holds a pending memory request and all its fields steady until `mem_req_ready` accepts it. A write is complete once it is accepted. A read is answered later by a one-cycle `mem_rsp_valid`. The page-table base is a plain input and is sampled when a request is accepted.

Top module: `pt_xlate_top`

## Requirements
- R1: On success, `xl_paddr` equals the entry's frame field (entry bits [31:12]) followed by the unchanged low 12 bits of the virtual address.
- R2: The entry is read from byte address `pt_base + vaddr[31:12]*4`, with `pt_base` sampled when the request is accepted.
- R3: If entry bit 0 (valid) is clear, the unit pulses `xl_fault` with `xl_cause` = 2'b01 (not present), gives no `xl_done`, and writes nothing to memory. This check takes priority over the write-permission check.
- R4: A store to a valid entry whose bit 3 (writable) is clear pulses `xl_fault` with `xl_cause` = 2'b10 (write-protect) and writes nothing to memory.
- R5: Every successful translation leaves entry bit 1 (referenced) set in memory.
- R6: A successful store also leaves entry bit 2 (dirty) set in memory.
- R7: The entry is written back only when its referenced or dirty bit changes. When both bits change, a single memory write carries both of them, and all other entry bits are left as read.
- R8: `req_ready` is low from acceptance until the result pulse. `xl_done` and `xl_fault` are never high together, and each lasts exactly one cycle.
- R9: A request that faulted as not present translates correctly when it is retried after the entry has been made valid.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the unit holds the memory request and its address, direction and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pt_base | input | 32 | Byte address of the page table, sampled at acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| xl_done | output | 1 | One-cycle pulse: translation succeeded |
| xl_paddr | output | 32 | Physical address, valid with `xl_done` |
| xl_fault | output | 1 | One-cycle pulse: translation faulted |
| xl_cause | output | 2 | Fault cause, 01 not present, 10 write-protect, 00 otherwise |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
The hardest case to reach is the update path. Reaching it needs an entry whose status bits are still clear. Whether a write happens then depends on the entry's history, and the memory may stall the write while it is pending. The vector table walks the same pages several times in a chosen order: first touch, repeated load, first store, and repeated store. The bench memory withdraws `mem_req_ready` on a fixed cadence, so requests sit stalled. The bench counts the writes it accepts per request and compares memory contents afterwards. The retry case is reached by changing the bench memory between two identical requests.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  // status bit positions inside a page table entry
  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_REF_BIT   = 1;
  localparam int unsigned PTE_DIRTY_BIT = 2;
  localparam int unsigned PTE_WRITE_BIT = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE        = 2'b00,
    CAUSE_NOT_PRESENT = 2'b01,
    CAUSE_WRITE_PROT  = 2'b10
  } fault_cause_e;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_RD_REQ,
    WK_RD_WAIT,
    WK_EVAL,
    WK_WR_REQ,
    WK_OK,
    WK_FAULT
  } walk_state_e;

endpackage

// File: rtl/pt_req_latch.sv
module pt_req_latch #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PA_W      = 32,
  localparam int unsigned IDX_W    = VA_W - PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [VA_W-1:0]      in_vaddr,
  input  logic                 in_store,
  input  logic [PA_W-1:0]      in_base,
  output logic [IDX_W-1:0]     page_idx,
  output logic [PAGE_BITS-1:0] page_off,
  output logic                 is_store,
  output logic [PA_W-1:0]      tbl_base
);

  logic [VA_W-1:0] vaddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q  <= '0;
      is_store <= 1'b0;
      tbl_base <= '0;
    end else if (take) begin
      vaddr_q  <= in_vaddr;
      is_store <= in_store;
      tbl_base <= in_base;
    end
  end

  assign page_idx = vaddr_q[VA_W-1:PAGE_BITS];
  assign page_off = vaddr_q[PAGE_BITS-1:0];

endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
  import pt_xlate_pkg::*;
#(
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned PA_W     = FRAME_W + PAGE_BITS
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic                 is_store,
  input  logic [PAGE_BITS-1:0] page_off,
  output logic                 present,
  output logic                 wp_hit,
  output logic [PTE_W-1:0]     pte_next,
  output logic                 needs_write,
  output logic [PA_W-1:0]      paddr
);

  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[PTE_REF_BIT] = 1'b1;
    if (is_store) set_mask[PTE_DIRTY_BIT] = 1'b1;
  end

  assign present     = pte[PTE_VALID_BIT];
  assign wp_hit      = is_store && !pte[PTE_WRITE_BIT];
  assign pte_next    = pte | set_mask;
  assign needs_write = (pte_next != pte);
  assign paddr       = {pte[PTE_W-1 -: FRAME_W], page_off};

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_xlate_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             take,
  input  logic [PA_W-1:0]  entry_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata,
  output logic [PTE_W-1:0] pte_q,
  input  logic             present,
  input  logic             wp_hit,
  input  logic             needs_write,
  input  logic [PTE_W-1:0] pte_next,
  output logic             done,
  output logic             fault,
  output logic [1:0]       cause
);

  walk_state_e  state_q, state_d;
  fault_cause_e cause_q, cause_d;

  assign req_ready = (state_q == WK_IDLE);
  assign take      = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      WK_IDLE:    if (take) state_d = WK_RD_REQ;
      WK_RD_REQ:  if (mem_req_ready) state_d = WK_RD_WAIT;
      WK_RD_WAIT: if (mem_rsp_valid) state_d = WK_EVAL;
      WK_EVAL: begin
        if (!present) begin
          state_d = WK_FAULT;
          cause_d = CAUSE_NOT_PRESENT;
        end else if (wp_hit) begin
          state_d = WK_FAULT;
          cause_d = CAUSE_WRITE_PROT;
        end else if (needs_write) begin
          state_d = WK_WR_REQ;
        end else begin
          state_d = WK_OK;
        end
      end
      WK_WR_REQ:  if (mem_req_ready) state_d = WK_OK;
      WK_OK:      state_d = WK_IDLE;
      WK_FAULT:   state_d = WK_IDLE;
      default:    state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      cause_q <= CAUSE_NONE;
      pte_q   <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (state_q == WK_RD_WAIT && mem_rsp_valid) pte_q <= mem_rsp_rdata;
    end
  end

  assign mem_req_valid = (state_q == WK_RD_REQ) || (state_q == WK_WR_REQ);
  assign mem_req_write = (state_q == WK_WR_REQ);
  assign mem_req_addr  = entry_addr;
  assign mem_req_wdata = (state_q == WK_WR_REQ) ? pte_next : '0;

  assign done  = (state_q == WK_OK);
  assign fault = (state_q == WK_FAULT);
  assign cause = fault ? cause_q : CAUSE_NONE;

  // R10: a stalled memory request keeps every field
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // R8: results never overlap
  assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R8: each result lasts one cycle, and no new request is taken meanwhile
  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!req_ready ##1 (!done && !fault)));

  // R5: any write-back carries the referenced and valid bits
  assert_wb_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |->
      (mem_req_wdata[PTE_REF_BIT] && mem_req_wdata[PTE_VALID_BIT]));

  // R3/R4: a fault is never preceded by a write-back of the same access
  assert_fault_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |=> !fault);

endmodule

// File: rtl/pt_xlate_top.sv
module pt_xlate_top
  import pt_xlate_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned PTE_W     = 32,
  localparam int unsigned PA_W     = FRAME_W + PAGE_BITS,
  localparam int unsigned IDX_W    = VA_W - PAGE_BITS,
  localparam int unsigned PTE_SH   = $clog2(PTE_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             xl_done,
  output logic [PA_W-1:0]  xl_paddr,
  output logic             xl_fault,
  output logic [1:0]       xl_cause,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata
);

  logic                 take;
  logic [IDX_W-1:0]     page_idx;
  logic [PAGE_BITS-1:0] page_off;
  logic                 is_store;
  logic [PA_W-1:0]      tbl_base;
  logic [PA_W-1:0]      entry_addr;
  logic [PTE_W-1:0]     pte_q;
  logic [PTE_W-1:0]     pte_next;
  logic                 present;
  logic                 wp_hit;
  logic                 needs_write;
  logic [PA_W-1:0]      paddr_c;

  pt_req_latch #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_vaddr(req_vaddr), .in_store(req_store), .in_base(pt_base),
    .page_idx(page_idx), .page_off(page_off), .is_store(is_store),
    .tbl_base(tbl_base)
  );

  assign entry_addr = tbl_base + (PA_W'(page_idx) << PTE_SH);

  pt_pte_eval #(
    .PTE_W(PTE_W), .FRAME_W(FRAME_W), .PAGE_BITS(PAGE_BITS)
  ) u_eval (
    .pte(pte_q), .is_store(is_store), .page_off(page_off),
    .present(present), .wp_hit(wp_hit), .pte_next(pte_next),
    .needs_write(needs_write), .paddr(paddr_c)
  );

  pt_walk_fsm #(
    .PTE_W(PTE_W), .PA_W(PA_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .take(take),
    .entry_addr(entry_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .pte_q(pte_q), .present(present), .wp_hit(wp_hit),
    .needs_write(needs_write), .pte_next(pte_next),
    .done(xl_done), .fault(xl_fault), .cause(xl_cause)
  );

  assign xl_paddr = xl_done ? paddr_c : '0;

endmodule

// File: tb/pt_xlate_top_tb.sv
`timescale 1ns/1ps
module pt_xlate_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = 32'h0000_1000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        xl_done, xl_fault;
  logic [31:0] xl_paddr;
  logic [1:0]  xl_cause;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #2 clk = ~clk;

  pt_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .xl_done(xl_done), .xl_paddr(xl_paddr),
    .xl_fault(xl_fault), .xl_cause(xl_cause),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: word index = byte address bits [12:2]
  logic [31:0] mem [0:2047];
  int          cyc = 0;
  int          rsp_cnt = 0;
  logic [31:0] rsp_data = '0;
  int          wr_count = 0;
  logic [31:0] last_wdata = '0;
  logic [31:0] last_rd_addr = '0;
  int          total = 0;
  int          bad = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt = rsp_cnt - 1;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rsp_data;
      end
    end
    mem_req_ready = (cyc % 3) != 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[12:2]] = mem_req_wdata;
        wr_count   = wr_count + 1;
        last_wdata = mem_req_wdata;
      end else begin
        last_rd_addr = mem_req_addr;
        rsp_data     = mem[mem_req_addr[12:2]];
        rsp_cnt      = 2;
      end
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // kind: 0 done, 1 not present, 2 write-protect, 3 timeout
  task automatic run_req(input logic [31:0] va, input logic st,
                         output logic [1:0] kind, output logic [31:0] pa);
    int n;
    wr_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "busy after accept", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!(xl_done || xl_fault) && n < 200) begin
      @(negedge clk);
      n = n + 1;
    end
    if (xl_done) begin kind = 2'd0; pa = xl_paddr; end
    else if (xl_fault) begin kind = xl_cause; pa = 32'h0; end
    else begin kind = 2'd3; pa = 32'h0; end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [1:0]  kind;
    logic [31:0] pa;
    logic [1:0]  nwr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1ABC, 1'b0, 2'd0, 32'h1234_5ABC, 2'd1, 4'd5},  // R5 first touch
    '{32'h0000_1000, 1'b0, 2'd0, 32'h1234_5000, 2'd0, 4'd7},  // R7 no change
    '{32'h0000_1FFF, 1'b1, 2'd0, 32'h1234_5FFF, 2'd1, 4'd6},  // R6 first store
    '{32'h0000_1004, 1'b1, 2'd0, 32'h1234_5004, 2'd0, 4'd7},  // R7 already dirty
    '{32'h0000_2010, 1'b1, 2'd2, 32'h0000_0000, 2'd0, 4'd4},  // R4 read-only
    '{32'h0000_2010, 1'b0, 2'd0, 32'h00AB_C010, 2'd1, 4'd1},  // R1 load on it
    '{32'h0000_3123, 1'b0, 2'd1, 32'h0000_0000, 2'd0, 4'd3},  // R3 not present
    '{32'h0000_4FFC, 1'b1, 2'd0, 32'hFFFF_FFFC, 2'd0, 4'd1}   // R1 top frame
  };

  initial begin
    logic [1:0]  k;
    logic [31:0] pa;
    string       rs;
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    mem[11'h401] = 32'h1234_5009;
    mem[11'h402] = 32'h00AB_C001;
    mem[11'h403] = 32'h0000_0008;
    mem[11'h404] = 32'hFFFF_F00F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R8)
    chk("R8", "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R8", "reset done", {31'd0, xl_done}, 32'd0);
    chk("R8", "reset fault", {31'd0, xl_fault}, 32'd0);
    chk("R10", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      rs = $sformatf("R%0d", VECS[v].rq);
      run_req(VECS[v].va, VECS[v].st, k, pa);
      chk(rs, $sformatf("vec%0d kind", v), {30'd0, k}, {30'd0, VECS[v].kind});
      chk(rs, $sformatf("vec%0d paddr", v), pa, VECS[v].pa);
      chk(rs, $sformatf("vec%0d writes", v), wr_count, {30'd0, VECS[v].nwr});
      // R2: entry address
      chk("R2", $sformatf("vec%0d entry addr", v), last_rd_addr,
          32'h0000_1000 + {VECS[v].va[31:12], 2'b00});
    end

    // resulting entries (R5, R6, R3, R4)
    chk("R6", "entry1 final", mem[11'h401], 32'h1234_500F);
    chk("R5", "entry2 final", mem[11'h402], 32'h00AB_C003);
    chk("R3", "entry3 untouched", mem[11'h403], 32'h0000_0008);
    chk("R7", "entry4 untouched", mem[11'h404], 32'hFFFF_F00F);

    // R9: fix the entry and retry the same request
    mem[11'h403] = 32'h0077_7009;
    run_req(32'h0000_3123, 1'b0, k, pa);
    chk("R9", "retry kind", {30'd0, k}, 32'd0);
    chk("R9", "retry paddr", pa, 32'h0077_7123);
    chk("R9", "retry entry", mem[11'h403], 32'h0077_700B);

    // R7: clean writable page stored to -> one write carrying both bits
    mem[11'h405] = 32'h0055_5009;
    run_req(32'h0000_5008, 1'b1, k, pa);
    chk("R7", "both-bit kind", {30'd0, k}, 32'd0);
    chk("R7", "both-bit writes", wr_count, 32'd1);
    chk("R7", "both-bit wdata", last_wdata, 32'h0055_500F);

    // R2: other base, sampled at accept
    pt_base = 32'h0000_1800;
    mem[11'h607] = 32'h0ABC_D00B;
    run_req(32'h0000_7ABC, 1'b0, k, pa);
    chk("R2", "base2 entry addr", last_rd_addr, 32'h0000_181C);
    chk("R1", "base2 paddr", pa, 32'h0ABC_DABC);
    chk("R7", "base2 writes", wr_count, 32'd0);

    // R3: not present wins over write permission on a store
    mem[11'h608] = 32'h0000_0008;
    run_req(32'h0000_8000, 1'b1, k, pa);
    chk("R3", "invalid store kind", {30'd0, k}, 32'd1);
    chk("R3", "invalid store writes", wr_count, 32'd0);
    chk("R3", "invalid store entry", mem[11'h608], 32'h0000_0008);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule